// File: doc/BRIEF.md
# Early Branch Target Verifier

This block sits in the decode stage and handles one group of up to `DECODE_W` fetched instructions per cycle, in program order. Entries that are already squashed are dropped, and the survivors are packed into the low output slots. Each forwarded entry is marked ready to issue when it reads no source registers. For every direct unconditional branch, the block compares the target computed at decode with the target the predictor supplied.

On the first disagreement the block still forwards the branch, with its target replaced by the computed one. It forwards nothing after that branch in the group. It issues a one-cycle redirect record for fetch. The record also carries a kill mask, which marks every incoming entry of the same thread that is younger by sequence number than the branch. An entry that was predicted taken but is not a control transfer raises an error pulse. Five running counters record decode activity.

All results are registered. A group presented at a clock edge produces its slots, redirect, error flag and counter updates on the following edge. Computing the targets and flushing the fetch buffers are left to neighbouring logic.

Top module: `early_br_verify`

## Requirements
- R1: While reset is high, and in the cycle after it is released with no group given, every output is zero: the valid flags, the slot count, the slots, the redirect fields, the kill mask, the error flag and all counters.
- R2: An entry with its squashed bit set is not forwarded. The remaining entries fill slots 0, 1, 2 and onward in input-lane order, `outCnt` gives their number, and any unused slot reads zero.
- R3: A forwarded entry has its can-issue bit set exactly when its source-register count is zero.
- R4: Only entries that are control, direct and unconditional all at once are checked. A direct conditional branch is never checked, even when its targets differ. `cntResolved` grows by the number of checked entries forwarded in the group.
- R5: At the first checked entry whose computed target differs from its predicted target, that entry is forwarded with the computed target in its slot, and no later lane of the group is forwarded.
- R6: On such a mismatch, one edge after the group, `redirValid`, `redirMispred`, `redirPredBad`, `redirSquash` and `redirTaken` are 1. `redirDoneSeq` carries the branch's sequence number, `redirNextPc` its computed target and `redirTid` its thread. All of these return to 0 on the next edge unless another mismatching group arrives.
- R7: Bit j of `redirKill` is set exactly when lane j has the same thread as the faulting branch and a sequence number greater than the branch's under an unsigned `SEQ_W`-bit compare, whatever position lane j holds. Without a mismatch the mask is zero.
- R8: A forwarded entry with predicted-taken set and the control bit clear raises `errOut` for one cycle, and each such entry adds 1 to `cntCtrlMispred`.
- R9: `cntDecoded` grows by the number of forwarded entries. `cntSquashed` grows by the number of squashed lanes met before the cut point. `cntMispred` grows by 1 per redirect.
- R10: With `grpValid` low, the next edge shows `outValid` at 0, `outCnt` at 0, no redirect and no error, and every counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| grpValid | input | 1 | Input group present this cycle |
| inSeq | input | DECODE_W*SEQ_W | Sequence number per lane |
| inTid | input | DECODE_W*TID_W | Thread per lane |
| inPredTaken | input | DECODE_W | Predicted-taken bit per lane |
| inPredTgt | input | DECODE_W*ADDR_W | Predicted target per lane |
| inCompTgt | input | DECODE_W*ADDR_W | Target computed at decode per lane |
| inIsCtrl | input | DECODE_W | Control-transfer flag per lane |
| inIsDirect | input | DECODE_W | Direct-target flag per lane |
| inIsUncond | input | DECODE_W | Unconditional flag per lane |
| inSquashed | input | DECODE_W | Already-squashed flag per lane |
| inSrcCnt | input | DECODE_W*SRC_W | Source-register count per lane |
| outValid | output | 1 | Output group valid |
| outCnt | output | $clog2(DECODE_W)+1 | Number of filled slots |
| outSeq | output | DECODE_W*SEQ_W | Sequence number per slot |
| outTid | output | DECODE_W*TID_W | Thread per slot |
| outTgt | output | DECODE_W*ADDR_W | Target per slot (corrected on mismatch) |
| outCanIssue | output | DECODE_W | Issue-ready bit per slot |
| redirValid | output | 1 | Redirect record valid |
| redirMispred | output | 1 | Branch mispredict flag |
| redirPredBad | output | 1 | Prediction-incorrect flag |
| redirSquash | output | 1 | Squash request flag |
| redirDoneSeq | output | SEQ_W | Sequence number of the faulting branch |
| redirNextPc | output | ADDR_W | Fetch restart address |
| redirTaken | output | 1 | Branch taken bit |
| redirTid | output | TID_W | Thread of the faulting branch |
| redirKill | output | DECODE_W | Input lanes to mark squashed |
| errOut | output | 1 | Predicted-taken non-control entry seen |
| cntDecoded | output | CNT_W | Forwarded entries |
| cntSquashed | output | CNT_W | Dropped squashed entries |
| cntResolved | output | CNT_W | Checked branches |
| cntMispred | output | CNT_W | Target mismatches |
| cntCtrlMispred | output | CNT_W | Predicted-taken non-control entries |

## Verification
The groups in the test table vary one feature at a time:
- A group with no special entries sets the baseline.
- Groups with squashed lanes in different positions show compaction apart from plain lane copying.
- Groups with a matching branch and with a mismatching branch show checking apart from cutting.
- A direct conditional branch with wrong targets placed ahead of a real mismatch shows that the check is limited to unconditional branches.

Two further groups test the kill mask. In one, a lane belongs to another thread. In the other, a lane after the branch holds an older sequence number. Together they show that the mask follows thread and sequence order, not lane position. Directed steps cover reset, the one-cycle life of the redirect, idle cycles that leave the counters unchanged, and a squashed lane after the cut that must not be counted.

// File: rtl/evb_pkg.sv
package evb_pkg;
  // Upper bound on group width carried by the strobe struct.
  localparam int MAX_LANES  = 8;
  localparam int LANE_IDX_W = $clog2(MAX_LANES);
  localparam int LANE_CNT_W = LANE_IDX_W + 1;

  // Strobes from the control scan to the datapath.
  typedef struct packed {
    logic [MAX_LANES-1:0]  fwdMask;
    logic                  misHit;
    logic [LANE_IDX_W-1:0] misLane;
    logic                  errHit;
    logic [LANE_CNT_W-1:0] squashedInc;
    logic [LANE_CNT_W-1:0] resolvedInc;
    logic [LANE_CNT_W-1:0] errInc;
  } evb_strobe_t;
endpackage

// File: rtl/evb_ctrl.sv
module evb_ctrl
  import evb_pkg::*;
#(
  parameter int DECODE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                grpValid,
  input  logic [DECODE_W-1:0] squashed,
  input  logic [DECODE_W-1:0] predTaken,
  input  logic [DECODE_W-1:0] isCtrl,
  input  logic [DECODE_W-1:0] isDirect,
  input  logic [DECODE_W-1:0] isUncond,
  input  logic [DECODE_W-1:0] tgtDiffer,
  output evb_strobe_t         strb
);

  // In-order scan; stops after the first target mismatch.
  always_comb begin
    logic stopped;
    strb    = '0;
    stopped = 1'b0;
    for (int i = 0; i < DECODE_W; i++) begin
      if (grpValid && !stopped) begin
        if (squashed[i]) begin
          strb.squashedInc = strb.squashedInc + LANE_CNT_W'(1);
        end else begin
          strb.fwdMask[i] = 1'b1;
          if (predTaken[i] && !isCtrl[i]) begin
            strb.errHit = 1'b1;
            strb.errInc = strb.errInc + LANE_CNT_W'(1);
          end
          if (isCtrl[i] && isDirect[i] && isUncond[i]) begin
            strb.resolvedInc = strb.resolvedInc + LANE_CNT_W'(1);
            if (tgtDiffer[i]) begin
              strb.misHit  = 1'b1;
              strb.misLane = LANE_IDX_W'(i);
              stopped      = 1'b1;
            end
          end
        end
      end
    end
  end

  // R2: a squashed lane is never forwarded
  a_r2_no_squashed_fwd: assert property (@(posedge clk) disable iff (rst)
    (strb.fwdMask[DECODE_W-1:0] & squashed) == '0);

  // R5: nothing past the faulting lane is forwarded
  a_r5_cut_after_miss: assert property (@(posedge clk) disable iff (rst)
    strb.misHit |-> ((strb.fwdMask >> strb.misLane) >> 1) == '0);

endmodule

// File: rtl/evb_dp.sv
module evb_dp
  import evb_pkg::*;
#(
  parameter int DECODE_W = 4,
  parameter int SEQ_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int SRC_W    = 3,
  parameter int TID_W    = 1,
  parameter int CNT_W    = 16,
  localparam int SLOT_W  = $clog2(DECODE_W)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       grpValid,
  input  logic [DECODE_W*SEQ_W-1:0]  inSeq,
  input  logic [DECODE_W*TID_W-1:0]  inTid,
  input  logic [DECODE_W*ADDR_W-1:0] inPredTgt,
  input  logic [DECODE_W*ADDR_W-1:0] inCompTgt,
  input  logic [DECODE_W*SRC_W-1:0]  inSrcCnt,
  input  evb_strobe_t                strb,
  output logic [DECODE_W-1:0]        tgtDiffer,
  output logic                       outValid,
  output logic [SLOT_W:0]            outCnt,
  output logic [DECODE_W*SEQ_W-1:0]  outSeq,
  output logic [DECODE_W*TID_W-1:0]  outTid,
  output logic [DECODE_W*ADDR_W-1:0] outTgt,
  output logic [DECODE_W-1:0]        outCanIssue,
  output logic                       redirValid,
  output logic                       redirMispred,
  output logic                       redirPredBad,
  output logic                       redirSquash,
  output logic [SEQ_W-1:0]           redirDoneSeq,
  output logic [ADDR_W-1:0]          redirNextPc,
  output logic                       redirTaken,
  output logic [TID_W-1:0]           redirTid,
  output logic [DECODE_W-1:0]        redirKill,
  output logic                       errOut,
  output logic [CNT_W-1:0]           cntDecoded,
  output logic [CNT_W-1:0]           cntSquashed,
  output logic [CNT_W-1:0]           cntResolved,
  output logic [CNT_W-1:0]           cntMispred,
  output logic [CNT_W-1:0]           cntCtrlMispred
);

  logic [SEQ_W-1:0]  laneSeq  [DECODE_W];
  logic [TID_W-1:0]  laneTid  [DECODE_W];
  logic [ADDR_W-1:0] lanePred [DECODE_W];
  logic [ADDR_W-1:0] laneComp [DECODE_W];
  logic [SRC_W-1:0]  laneSrc  [DECODE_W];

  logic [SEQ_W-1:0]  slotSeq  [DECODE_W];
  logic [TID_W-1:0]  slotTid  [DECODE_W];
  logic [ADDR_W-1:0] slotTgt  [DECODE_W];
  logic [DECODE_W-1:0] slotIss;

  logic [SEQ_W-1:0]  nSeq [DECODE_W];
  logic [TID_W-1:0]  nTid [DECODE_W];
  logic [ADDR_W-1:0] nTgt [DECODE_W];
  logic [DECODE_W-1:0] nIss;
  logic [SLOT_W:0]     nCnt;
  logic [DECODE_W-1:0] nKill;
  logic [SLOT_W-1:0]   misIdx;

  assign misIdx = strb.misLane[SLOT_W-1:0];

  for (genvar g = 0; g < DECODE_W; g++) begin : g_lane
    assign laneSeq[g]  = inSeq[g*SEQ_W +: SEQ_W];
    assign laneTid[g]  = inTid[g*TID_W +: TID_W];
    assign lanePred[g] = inPredTgt[g*ADDR_W +: ADDR_W];
    assign laneComp[g] = inCompTgt[g*ADDR_W +: ADDR_W];
    assign laneSrc[g]  = inSrcCnt[g*SRC_W +: SRC_W];
    assign tgtDiffer[g] = lanePred[g] != laneComp[g];
    assign outSeq[g*SEQ_W +: SEQ_W]    = slotSeq[g];
    assign outTid[g*TID_W +: TID_W]    = slotTid[g];
    assign outTgt[g*ADDR_W +: ADDR_W]  = slotTgt[g];
    // Younger same-thread lanes get killed by the redirect.
    assign nKill[g] = strb.misHit && (laneTid[g] == laneTid[misIdx]) &&
                      (laneSeq[g] > laneSeq[misIdx]);
  end
  assign outCanIssue = slotIss;

  // Pack forwarded lanes into the low slots.
  always_comb begin
    nCnt = '0;
    nIss = '0;
    for (int s = 0; s < DECODE_W; s++) begin
      nSeq[s] = '0;
      nTid[s] = '0;
      nTgt[s] = '0;
    end
    for (int i = 0; i < DECODE_W; i++) begin
      if (strb.fwdMask[i]) begin
        nSeq[nCnt[SLOT_W-1:0]] = laneSeq[i];
        nTid[nCnt[SLOT_W-1:0]] = laneTid[i];
        nTgt[nCnt[SLOT_W-1:0]] = (strb.misHit && (misIdx == SLOT_W'(i))) ?
                                 laneComp[i] : lanePred[i];
        nIss[nCnt[SLOT_W-1:0]] = laneSrc[i] == '0;
        nCnt = nCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid       <= 1'b0;
      outCnt         <= '0;
      slotIss        <= '0;
      redirValid     <= 1'b0;
      redirMispred   <= 1'b0;
      redirPredBad   <= 1'b0;
      redirSquash    <= 1'b0;
      redirDoneSeq   <= '0;
      redirNextPc    <= '0;
      redirTaken     <= 1'b0;
      redirTid       <= '0;
      redirKill      <= '0;
      errOut         <= 1'b0;
      cntDecoded     <= '0;
      cntSquashed    <= '0;
      cntResolved    <= '0;
      cntMispred     <= '0;
      cntCtrlMispred <= '0;
      for (int s = 0; s < DECODE_W; s++) begin
        slotSeq[s] <= '0;
        slotTid[s] <= '0;
        slotTgt[s] <= '0;
      end
    end else begin
      outValid <= grpValid;
      outCnt   <= nCnt;
      slotIss  <= nIss;
      for (int s = 0; s < DECODE_W; s++) begin
        slotSeq[s] <= nSeq[s];
        slotTid[s] <= nTid[s];
        slotTgt[s] <= nTgt[s];
      end
      redirValid   <= strb.misHit;
      redirMispred <= strb.misHit;
      redirPredBad <= strb.misHit;
      redirSquash  <= strb.misHit;
      redirTaken   <= strb.misHit;
      redirDoneSeq <= strb.misHit ? laneSeq[misIdx]  : '0;
      redirNextPc  <= strb.misHit ? laneComp[misIdx] : '0;
      redirTid     <= strb.misHit ? laneTid[misIdx]  : '0;
      redirKill    <= nKill;
      errOut       <= strb.errHit;
      cntDecoded     <= cntDecoded + CNT_W'(nCnt);
      cntSquashed    <= cntSquashed + CNT_W'(strb.squashedInc);
      cntResolved    <= cntResolved + CNT_W'(strb.resolvedInc);
      cntMispred     <= cntMispred + CNT_W'(strb.misHit);
      cntCtrlMispred <= cntCtrlMispred + CNT_W'(strb.errInc);
    end
  end

  // R5: the last filled slot holds the corrected branch target
  a_r5_last_slot_target: assert property (@(posedge clk) disable iff (rst)
    redirValid |-> (outCnt != '0) &&
                   (slotTgt[SLOT_W'(outCnt - 1'b1)] == redirNextPc));

  // R6: the done point names the last forwarded entry
  a_r6_done_seq_slot: assert property (@(posedge clk) disable iff (rst)
    redirValid |-> slotSeq[SLOT_W'(outCnt - 1'b1)] == redirDoneSeq);

  // R10: no group means no slots, redirect or error
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outCnt == '0) && !redirValid && !errOut);

  // R9: decoded counter steps by the slot count
  a_r9_decoded_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cntDecoded == $past(cntDecoded) + CNT_W'(outCnt));

endmodule

// File: rtl/early_br_verify.sv
module early_br_verify
  import evb_pkg::*;
#(
  parameter int DECODE_W = 4,
  parameter int SEQ_W    = 16,
  parameter int ADDR_W   = 32,
  parameter int SRC_W    = 3,
  parameter int TID_W    = 1,
  parameter int CNT_W    = 16,
  localparam int SLOT_W  = $clog2(DECODE_W)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       grpValid,
  input  logic [DECODE_W*SEQ_W-1:0]  inSeq,
  input  logic [DECODE_W*TID_W-1:0]  inTid,
  input  logic [DECODE_W-1:0]        inPredTaken,
  input  logic [DECODE_W*ADDR_W-1:0] inPredTgt,
  input  logic [DECODE_W*ADDR_W-1:0] inCompTgt,
  input  logic [DECODE_W-1:0]        inIsCtrl,
  input  logic [DECODE_W-1:0]        inIsDirect,
  input  logic [DECODE_W-1:0]        inIsUncond,
  input  logic [DECODE_W-1:0]        inSquashed,
  input  logic [DECODE_W*SRC_W-1:0]  inSrcCnt,
  output logic                       outValid,
  output logic [SLOT_W:0]            outCnt,
  output logic [DECODE_W*SEQ_W-1:0]  outSeq,
  output logic [DECODE_W*TID_W-1:0]  outTid,
  output logic [DECODE_W*ADDR_W-1:0] outTgt,
  output logic [DECODE_W-1:0]        outCanIssue,
  output logic                       redirValid,
  output logic                       redirMispred,
  output logic                       redirPredBad,
  output logic                       redirSquash,
  output logic [SEQ_W-1:0]           redirDoneSeq,
  output logic [ADDR_W-1:0]          redirNextPc,
  output logic                       redirTaken,
  output logic [TID_W-1:0]           redirTid,
  output logic [DECODE_W-1:0]        redirKill,
  output logic                       errOut,
  output logic [CNT_W-1:0]           cntDecoded,
  output logic [CNT_W-1:0]           cntSquashed,
  output logic [CNT_W-1:0]           cntResolved,
  output logic [CNT_W-1:0]           cntMispred,
  output logic [CNT_W-1:0]           cntCtrlMispred
);

  // DECODE_W must lie in 2..MAX_LANES.
  evb_strobe_t         strb;
  logic [DECODE_W-1:0] tgtDiffer;

  evb_ctrl #(.DECODE_W(DECODE_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .grpValid  (grpValid),
    .squashed  (inSquashed),
    .predTaken (inPredTaken),
    .isCtrl    (inIsCtrl),
    .isDirect  (inIsDirect),
    .isUncond  (inIsUncond),
    .tgtDiffer (tgtDiffer),
    .strb      (strb)
  );

  evb_dp #(
    .DECODE_W(DECODE_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
    .SRC_W(SRC_W), .TID_W(TID_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk            (clk),
    .rst            (rst),
    .grpValid       (grpValid),
    .inSeq          (inSeq),
    .inTid          (inTid),
    .inPredTgt      (inPredTgt),
    .inCompTgt      (inCompTgt),
    .inSrcCnt       (inSrcCnt),
    .strb           (strb),
    .tgtDiffer      (tgtDiffer),
    .outValid       (outValid),
    .outCnt         (outCnt),
    .outSeq         (outSeq),
    .outTid         (outTid),
    .outTgt         (outTgt),
    .outCanIssue    (outCanIssue),
    .redirValid     (redirValid),
    .redirMispred   (redirMispred),
    .redirPredBad   (redirPredBad),
    .redirSquash    (redirSquash),
    .redirDoneSeq   (redirDoneSeq),
    .redirNextPc    (redirNextPc),
    .redirTaken     (redirTaken),
    .redirTid       (redirTid),
    .redirKill      (redirKill),
    .errOut         (errOut),
    .cntDecoded     (cntDecoded),
    .cntSquashed    (cntSquashed),
    .cntResolved    (cntResolved),
    .cntMispred     (cntMispred),
    .cntCtrlMispred (cntCtrlMispred)
  );

endmodule

// File: tb/sim_early_br_verify.sv
`timescale 1ns/1ps
module sim_early_br_verify;
  localparam int W  = 4;
  localparam int SQ = 16;
  localparam int AW = 32;
  localparam int SW = 3;
  localparam int TW = 1;
  localparam int CW = 16;
  localparam int NV = 12;

  // Lane code, one byte per lane (lane 0 in the low byte):
  // b0 squashed, b1 direct uncond branch, b2 targets differ, b3 no sources,
  // b4 predicted taken non-control, b5 thread 1, b6 older seq, b7 direct cond branch
  localparam logic [31:0] VEC [NV] = '{
    32'h00000000, 32'h01000100, 32'h00080008, 32'h00000200,
    32'h00000600, 32'h00200006, 32'h40000600, 32'h00060084,
    32'h00001000, 32'h01010101, 32'h00000106, 32'h0E000000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grpValid = 1'b0;
  logic [W*SQ-1:0] inSeq = '0;
  logic [W*TW-1:0] inTid = '0;
  logic [W-1:0] inPredTaken = '0, inIsCtrl = '0, inIsDirect = '0;
  logic [W-1:0] inIsUncond = '0, inSquashed = '0;
  logic [W*AW-1:0] inPredTgt = '0, inCompTgt = '0;
  logic [W*SW-1:0] inSrcCnt = '0;

  logic outValid, redirValid, redirMispred, redirPredBad, redirSquash;
  logic redirTaken, errOut;
  logic [2:0] outCnt;
  logic [W*SQ-1:0] outSeq;
  logic [W*TW-1:0] outTid;
  logic [W*AW-1:0] outTgt;
  logic [W-1:0] outCanIssue, redirKill;
  logic [SQ-1:0] redirDoneSeq;
  logic [AW-1:0] redirNextPc;
  logic [TW-1:0] redirTid;
  logic [CW-1:0] cntDecoded, cntSquashed, cntResolved, cntMispred, cntCtrlMispred;

  always #2.5 clk = ~clk;

  early_br_verify #(.DECODE_W(W), .SEQ_W(SQ), .ADDR_W(AW), .SRC_W(SW),
                    .TID_W(TW), .CNT_W(CW)) u0 (.*);

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  // expected counters
  int eDec = 0, eSq = 0, eRes = 0, eMis = 0, eErr = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chkCounters(input string req);
    chk(req, "cntDecoded", 64'(cntDecoded), 64'(eDec));
    chk(req, "cntSquashed", 64'(cntSquashed), 64'(eSq));
    chk(req, "cntResolved", 64'(cntResolved), 64'(eRes));
    chk(req, "cntMispred", 64'(cntMispred), 64'(eMis));
    chk(req, "cntCtrlMispred", 64'(cntCtrlMispred), 64'(eErr));
  endtask

  // Drive a group from a code word, predict results, check after one edge.
  task automatic runVec(input int v, input logic [31:0] code);
    logic [SQ-1:0] sq [W];
    logic [TW-1:0] td [W];
    logic [AW-1:0] pt [W], ct [W];
    logic [AW-1:0] expTgt [W];
    logic [SQ-1:0] expSeq [W];
    logic [W-1:0] expIss, expKill;
    int k, misL;
    bit stop, err;
    for (int i = 0; i < W; i++) begin
      logic [7:0] c;
      c = code[i*8 +: 8];
      sq[i] = c[6] ? SQ'(16'h100 + v*16 - 8) : SQ'(16'h100 + v*16 + i);
      td[i] = TW'(c[5]);
      pt[i] = AW'(32'h4000 + v*256 + i*16);
      ct[i] = c[2] ? pt[i] + 32'h40 : pt[i];
      inSeq[i*SQ +: SQ]     = sq[i];
      inTid[i*TW +: TW]     = td[i];
      inPredTgt[i*AW +: AW] = pt[i];
      inCompTgt[i*AW +: AW] = ct[i];
      inSrcCnt[i*SW +: SW]  = c[3] ? SW'(0) : SW'(2);
      inSquashed[i]  = c[0];
      inIsCtrl[i]    = c[1] | c[7];
      inIsDirect[i]  = c[1] | c[7];
      inIsUncond[i]  = c[1];
      inPredTaken[i] = c[1] | c[4] | c[7];
    end
    // reference from the requirements
    k = 0; misL = -1; stop = 0; err = 0; expIss = '0; expKill = '0;
    for (int s = 0; s < W; s++) begin expSeq[s] = '0; expTgt[s] = '0; end
    for (int i = 0; i < W; i++) begin
      logic [7:0] c;
      c = code[i*8 +: 8];
      if (!stop) begin
        if (c[0]) eSq++;
        else begin
          expSeq[k] = sq[i];
          expTgt[k] = pt[i];
          expIss[k] = c[3];
          if (c[4]) begin err = 1; eErr++; end
          if (c[1]) begin
            eRes++;
            if (c[2]) begin expTgt[k] = ct[i]; misL = i; stop = 1; eMis++; end
          end
          k++; eDec++;
        end
      end
    end
    if (misL >= 0)
      for (int j = 0; j < W; j++)
        expKill[j] = (td[j] == td[misL]) && (sq[j] > sq[misL]);
    grpValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    grpValid = 1'b0;
    chk("R2", $sformatf("v%0d outCnt", v), 64'(outCnt), 64'(k));
    chk("R10", $sformatf("v%0d outValid", v), 64'(outValid), 64'(1));
    for (int s = 0; s < W; s++) begin
      chk("R2", $sformatf("v%0d seq%0d", v, s), 64'(outSeq[s*SQ +: SQ]), 64'(expSeq[s]));
      chk("R5", $sformatf("v%0d tgt%0d", v, s), 64'(outTgt[s*AW +: AW]), 64'(expTgt[s]));
    end
    chk("R3", $sformatf("v%0d canIssue", v), 64'(outCanIssue), 64'(expIss));
    chk("R6", $sformatf("v%0d redirValid", v), 64'(redirValid), 64'(misL >= 0));
    chk("R6", $sformatf("v%0d flags", v),
        64'({redirMispred, redirPredBad, redirSquash, redirTaken}),
        (misL >= 0) ? 64'hF : 64'h0);
    chk("R6", $sformatf("v%0d doneSeq", v), 64'(redirDoneSeq), (misL >= 0) ? 64'(sq[misL]) : 64'h0);
    chk("R6", $sformatf("v%0d nextPc", v), 64'(redirNextPc), (misL >= 0) ? 64'(ct[misL]) : 64'h0);
    chk("R6", $sformatf("v%0d tid", v), 64'(redirTid), (misL >= 0) ? 64'(td[misL]) : 64'h0);
    chk("R7", $sformatf("v%0d kill", v), 64'(redirKill), 64'(expKill));
    chk("R8", $sformatf("v%0d errOut", v), 64'(errOut), 64'(err));
    chkCounters("R9 R4");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "outValid", 64'(outValid), 0);
    chk("R1", "outCnt", 64'(outCnt), 0);
    chk("R1", "slots", 64'(outSeq) | 64'(outTgt) | 64'(outCanIssue), 0);
    chk("R1", "redirect", 64'({redirValid, redirMispred, redirPredBad, redirSquash,
                               redirTaken, redirKill, errOut}), 0);
    chkCounters("R1");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "after release outValid", 64'(outValid), 0);
    chkCounters("R1");

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) runVec(v, VEC[v]);

    // R6: redirect lives one cycle; R10: idle edge leaves counters alone
    runVec(20, 32'h00000600);
    @(posedge clk);
    @(negedge clk);
    chk("R6", "redirect dropped", 64'({redirValid, redirMispred, redirSquash, redirTaken}), 0);
    chk("R10", "idle outValid", 64'(outValid), 0);
    chk("R10", "idle outCnt", 64'(outCnt), 0);
    chk("R10", "idle errOut", 64'(errOut), 0);
    chkCounters("R10");

    // R4: conditional branch with differing targets alone is not checked
    runVec(21, 32'h00000084);
    chk("R4", "cond no redirect", 64'(redirValid), 0);

    // R1: reset mid-run clears counters
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    eDec = 0; eSq = 0; eRes = 0; eMis = 0; eErr = 0;
    chkCounters("R1");
    rst = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule